// File: doc/BRIEF.md
# Data-Space Region Decoder with External Memory Sequencer

This block sits between a small CPU's data port and the memories behind it. Each request carries a 16-bit address and a read or write strobe. The block classifies the address into one of five regions: working registers, standard I/O, extended I/O, on-chip SRAM, or off-chip SRAM. It reports the region as a one-hot select and returns the matching read data. On-chip regions complete in the request cycle, and the off-chip bus stays quiet while they are served.

Off-chip addresses go through a small sequencer. It latches the address and write data, drives an active-low read or write strobe, and holds the CPU with a low ready. The hold lasts for one fixed extra cycle plus 0 to 3 wait states. A gate input allows or blocks off-chip access. A layout input picks between two maps. The full map carries extended I/O. The compact legacy map has no extended I/O and moves on-chip SRAM down to sit right after the I/O window.

Top module: `dmem_router`

## Requirements
- R1: With `legacy` low, addresses 0x0000-0x001F give `sel` = 5'b00001, 0x0020-0x005F give 5'b00010, 0x0060-0x00FF give 5'b00100, 0x0100-0x04FF give 5'b01000, and 0x0500-0xFFFF give 5'b10000 (with `xmem_en` high). At most one bit of `sel` is ever set.
- R2: With `legacy` high, 0x0000-0x001F give `sel` bit 0 and 0x0020-0x005F give bit 1. Bit 2 is never set, 0x0060-0x045F give bit 3, and 0x0460-0xFFFF give bit 4 (with `xmem_en` high).
- R3: Every address above the on-chip SRAM top of the active layout, up to 0xFFFF, is treated as off-chip.
- R4: An on-chip hit has `cpu_ready` high in the same cycle, keeps `xm_rd_n` and `xm_wr_n` high, and puts `int_rdata` on `cpu_rdata` for reads.
- R5: An enabled off-chip access with `wait_cfg` = 0 holds `cpu_ready` low for exactly one cycle.
- R6: With `wait_cfg` = w, an enabled off-chip access holds `cpu_ready` low for exactly 1+w cycles. `wait_cfg` is sampled only in the first cycle of the access.
- R7: Both strobes are high in the first cycle of an off-chip access. From the second cycle through the final cycle, exactly one strobe is low (`xm_rd_n` for reads, `xm_wr_n` for writes). Over that span `xm_addr` equals the CPU address and, for writes, `xm_wdata` equals the write data. The two strobes are never low together.
- R8: In the final cycle of an off-chip read (`cpu_ready` high), `cpu_rdata` equals `xm_rdata`.
- R9: With `xmem_en` low, an off-chip address gives `sel` = 0, both strobes high, `cpu_ready` high in the request cycle, and `cpu_rdata` = 0 on reads.
- R10: With neither `cpu_rd` nor `cpu_wr` set, `sel` is 0 and `cpu_ready` is high.
- R11: A request with both `cpu_rd` and `cpu_wr` set is served as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy | input | 1 | 1 selects the compact layout without extended I/O |
| xmem_en | input | 1 | 1 allows off-chip accesses |
| wait_cfg | input | 2 | Off-chip wait states, 0 to 3 |
| cpu_addr | input | 16 | Data address |
| cpu_rd | input | 1 | Read request, held until ready |
| cpu_wr | input | 1 | Write request, held until ready |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| cpu_ready | output | 1 | Low while the CPU must hold its request |
| sel | output | 5 | One-hot region: bit 0 registers, bit 1 I/O, bit 2 extended I/O, bit 3 on-chip SRAM, bit 4 off-chip |
| int_rdata | input | 8 | Read data from the selected on-chip region |
| xm_addr | output | 16 | Off-chip bus address |
| xm_wdata | output | 8 | Off-chip bus write data |
| xm_rdata | input | 8 | Off-chip bus read data |
| xm_rd_n | output | 1 | Active-low off-chip read strobe |
| xm_wr_n | output | 1 | Active-low off-chip write strobe |

## Verification
Directed addresses on both sides of every region edge, in both layouts, separate an off-by-one limit from a layout swap. Random addresses are weighted toward the low 1.5 KB, which exercises the region decode. Random full-range addresses exercise the off-chip path. Each random access draws its read/write mix, gate and wait-state count at random. Changing `wait_cfg` right after each access starts shows whether the count is latched rather than read live. Disabled off-chip accesses and requests with both strobes set tell the gate and the write priority apart from the normal path.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [2:0] {
    RG_REGF  = 3'd0,
    RG_IO    = 3'd1,
    RG_XIO   = 3'd2,
    RG_ISRAM = 3'd3,
    RG_XSRAM = 3'd4,
    RG_NONE  = 3'd5
  } region_e;

  localparam int NUM_SEL = 5;
endpackage

// File: rtl/dmem_region_dec.sv
module dmem_region_dec
  import dmem_pkg::*;
#(
  parameter int AW       = 16,
  parameter int REGF_SZ  = 32,
  parameter int IO_SZ    = 64,
  parameter int XIO_SZ   = 160,
  parameter int ISRAM_SZ = 1024
) (
  input  logic [AW-1:0] addr,
  input  logic          legacy,
  output region_e       region
);
  localparam int unsigned REGF_END   = REGF_SZ;
  localparam int unsigned IO_END     = REGF_END + IO_SZ;
  localparam int unsigned XIO_END    = IO_END + XIO_SZ;
  localparam int unsigned FULL_TOP   = XIO_END + ISRAM_SZ;
  localparam int unsigned LEGACY_TOP = IO_END + ISRAM_SZ;

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    if (a32 < REGF_END)                  region = RG_REGF;
    else if (a32 < IO_END)               region = RG_IO;
    else if (legacy) begin
      if (a32 < LEGACY_TOP)              region = RG_ISRAM;
      else                               region = RG_XSRAM;
    end else begin
      if (a32 < XIO_END)                 region = RG_XIO;
      else if (a32 < FULL_TOP)           region = RG_ISRAM;
      else                               region = RG_XSRAM;
    end
  end
endmodule

// File: rtl/dmem_ext_seq.sv
module dmem_ext_seq #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           is_wr,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [WSW-1:0] wait_i,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  xm_addr,
  output logic [DW-1:0]  xm_wdata,
  output logic           xm_rd_n,
  output logic           xm_wr_n
);
  logic           busy_q;
  logic [WSW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      xm_addr  <= '0;
      xm_wdata <= '0;
      xm_rd_n  <= 1'b1;
      xm_wr_n  <= 1'b1;
    end else if (!busy_q) begin
      if (start) begin
        busy_q   <= 1'b1;
        cnt_q    <= wait_i;
        xm_addr  <= addr_i;
        xm_wdata <= wdata_i;
        xm_rd_n  <= is_wr;
        xm_wr_n  <= !is_wr;
      end
    end else if (cnt_q == '0) begin
      busy_q  <= 1'b0;
      xm_rd_n <= 1'b1;
      xm_wr_n <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    xm_rd_n || xm_wr_n);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> ($stable(xm_addr) && $stable(xm_wdata) &&
                           $stable(xm_rd_n) && $stable(xm_wr_n)));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (xm_rd_n && xm_wr_n));

  assert_start_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> (busy && (!xm_rd_n || !xm_wr_n)));
endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int WSW      = 2,
  parameter int REGF_SZ  = 32,
  parameter int IO_SZ    = 64,
  parameter int XIO_SZ   = 160,
  parameter int ISRAM_SZ = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               legacy,
  input  logic               xmem_en,
  input  logic [WSW-1:0]     wait_cfg,
  input  logic [AW-1:0]      cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_ready,
  output logic [NUM_SEL-1:0] sel,
  input  logic [DW-1:0]      int_rdata,
  output logic [AW-1:0]      xm_addr,
  output logic [DW-1:0]      xm_wdata,
  input  logic [DW-1:0]      xm_rdata,
  output logic               xm_rd_n,
  output logic               xm_wr_n
);
  region_e raw_region, region;
  logic    req, rd_op, ext_live, internal_hit, seq_busy, seq_done, start;

  dmem_region_dec #(
    .AW(AW), .REGF_SZ(REGF_SZ), .IO_SZ(IO_SZ),
    .XIO_SZ(XIO_SZ), .ISRAM_SZ(ISRAM_SZ)
  ) u_dec (
    .addr   (cpu_addr),
    .legacy (legacy),
    .region (raw_region)
  );

  assign req      = cpu_rd || cpu_wr;
  assign rd_op    = cpu_rd && !cpu_wr;
  assign region   = (!req || (raw_region == RG_XSRAM && !xmem_en)) ? RG_NONE : raw_region;
  assign ext_live = (region == RG_XSRAM);
  assign internal_hit = req && (region != RG_NONE) && !ext_live;
  assign start    = ext_live && !seq_busy;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign sel[i] = (region == region_e'(i));
  end

  dmem_ext_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .is_wr    (cpu_wr),
    .addr_i   (cpu_addr),
    .wdata_i  (cpu_wdata),
    .wait_i   (wait_cfg),
    .busy     (seq_busy),
    .done     (seq_done),
    .xm_addr  (xm_addr),
    .xm_wdata (xm_wdata),
    .xm_rd_n  (xm_rd_n),
    .xm_wr_n  (xm_wr_n)
  );

  assign cpu_ready = !ext_live || seq_done;

  always_comb begin
    if (internal_hit && rd_op)           cpu_rdata = int_rdata;
    else if (ext_live && seq_done && rd_op) cpu_rdata = xm_rdata;
    else                                 cpu_rdata = '0;
  end

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  assert_no_xio_legacy_R2: assert property (@(posedge clk) disable iff (rst)
    legacy |-> !sel[2]);

  assert_internal_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (req && (sel[0] || sel[1] || sel[2] || sel[3])) |-> (cpu_ready && xm_rd_n && xm_wr_n));

  assert_blocked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> (cpu_ready && xm_rd_n && xm_wr_n));

  assert_first_cycle_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (sel[4] && xm_rd_n && xm_wr_n) |-> !cpu_ready);
endmodule

// File: tb/dmem_router_test.sv
module dmem_router_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        legacy = 1'b0, xmem_en = 1'b0;
  logic [1:0]  wait_cfg = 2'd0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata, int_rdata, xm_wdata, xm_rdata;
  logic        cpu_ready, xm_rd_n, xm_wr_n;
  logic [4:0]  sel;
  logic [15:0] xm_addr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign int_rdata = cpu_addr[7:0] + cpu_addr[15:8] + 8'h3C;
  assign xm_rdata  = xm_addr[7:0] ^ xm_addr[15:8] ^ 8'hA5;

  dmem_router uut (
    .clk(clk), .rst(rst), .legacy(legacy), .xmem_en(xmem_en), .wait_cfg(wait_cfg),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .sel(sel), .int_rdata(int_rdata),
    .xm_addr(xm_addr), .xm_wdata(xm_wdata), .xm_rdata(xm_rdata),
    .xm_rd_n(xm_rd_n), .xm_wr_n(xm_wr_n)
  );

  function automatic int exp_region(input logic [15:0] a, input bit leg);
    if (a < 16'h0020) return 0;
    if (a < 16'h0060) return 1;
    if (leg) return (a < 16'h0460) ? 3 : 4;
    if (a < 16'h0100) return 2;
    if (a < 16'h0500) return 3;
    return 4;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_access(input logic [15:0] a, input bit rd, input bit wr,
                            input logic [7:0] wd, input bit leg, input bit en,
                            input logic [1:0] w);
    int    rg = exp_region(a, leg);
    bit    live = (rg == 4) && en;
    int    extra = live ? 1 + int'(w) : 0;
    logic [4:0] sel_exp = (rg == 4 && !en) ? 5'd0 : 5'(1 << rg);
    string stag = (rg == 4 && !en) ? "R9" : (rg == 4 ? "R3" : (leg ? "R2" : "R1"));
    logic [7:0] rd_exp;
    int lowcnt = 0;
    int cyc = 0;
    bit fin = 0;
    if (!live) rd_exp = (rg == 4) ? 8'h00 : (a[7:0] + a[15:8] + 8'h3C);
    else       rd_exp = a[7:0] ^ a[15:8] ^ 8'hA5;
    @(negedge clk);
    legacy = leg; xmem_en = en; wait_cfg = w;
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    while (!fin && cyc < 12) begin
      #1;
      check(sel == sel_exp, stag, sel, sel_exp);
      if (cyc == 0 || !live) begin
        check(xm_rd_n && xm_wr_n, live ? "R7" : (rg == 4 ? "R9" : "R4"),
              {xm_rd_n, xm_wr_n}, 2'b11);
      end else begin
        check({xm_rd_n, xm_wr_n} == (wr ? 2'b10 : 2'b01), wr && rd ? "R11" : "R7",
              {xm_rd_n, xm_wr_n}, wr ? 2'b10 : 2'b01);
        check(xm_addr == a, "R7", xm_addr, a);
        if (wr) check(xm_wdata == wd, "R7", xm_wdata, wd);
      end
      if (!cpu_ready) lowcnt++;
      else begin
        fin = 1;
        if (rd && !wr)
          check(cpu_rdata == rd_exp, live ? "R8" : (rg == 4 ? "R9" : "R4"), cpu_rdata, rd_exp);
      end
      @(negedge clk);
      cyc++;
      if (cyc == 1) wait_cfg = ~w;
    end
    check(lowcnt == extra, live ? (w == 0 ? "R5" : "R6") : (rg == 4 ? "R9" : "R4"),
          lowcnt, extra);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #1;
    check(cpu_ready && sel == 5'd0 && xm_rd_n && xm_wr_n, "R10",
          {cpu_ready, sel, xm_rd_n, xm_wr_n}, 8'b10000011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] edges [12];
    void'($urandom(32'd4021));
    edges = '{16'h001F, 16'h0020, 16'h005F, 16'h0060, 16'h00FF, 16'h0100,
              16'h045F, 16'h0460, 16'h04FF, 16'h0500, 16'hFFFF, 16'h0000};
    repeat (3) @(negedge clk);
    #1;
    check(cpu_ready && sel == 5'd0 && xm_rd_n && xm_wr_n, "R10",
          {cpu_ready, sel, xm_rd_n, xm_wr_n}, 8'b10000011);
    rst = 1'b0;
    // R1 R2 R3 region edges, both layouts
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 12; i++) begin
        run_access(edges[i], 1'b1, 1'b0, 8'h00, m[0], 1'b1, 2'd0);
      end
    end
    // R5 R6 each wait count, read and write
    for (int w = 0; w < 4; w++) begin
      run_access(16'h8000 + 16'(w), 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 2'(w));
      run_access(16'h0460 + 16'(w), 1'b0, 1'b1, 8'h5A + 8'(w), 1'b1, 1'b1, 2'(w));
    end
    // R9 gate closed, R11 both strobes
    run_access(16'hC123, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 2'd3);
    run_access(16'hC124, 1'b0, 1'b1, 8'h77, 1'b1, 1'b0, 2'd2);
    run_access(16'h9001, 1'b1, 1'b1, 8'hE1, 1'b0, 1'b1, 2'd1);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      int op = int'($urandom_range(0, 9));
      a = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 16'h05FF)) : 16'($urandom);
      run_access(a, op != 0 && op < 6 || op == 9, op == 0 || op >= 6,
                 8'($urandom), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 4) != 0, 2'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule